// File: doc/BRIEF.md
# Dual-Port Busy Arbiter with Write Inhibit

This block sits in front of a two-port memory and watches both ports for address collisions. A collision means both ports are selected and present the same address at the same time. When one occurs, the arbiter lets one port continue. It drives an active-low busy flag toward the other port and blocks that port's write strobe internally. The storage array never sees a write from a port that is marked busy. The busy decision depends only on the chip selects and the addresses. Whether an access is a read or a write plays no part in it.

A mode input chooses between two roles. As the deciding unit, the block arbitrates and drives both busy outputs. As a follower, it makes no decision of its own: it holds its busy outputs inactive and treats the two busy inputs as plain write inhibits. This lets several follower slices placed side by side obey one deciding unit. The write gate acts on a busy state captured at the previous clock edge, never on a combinational value that is still settling. Busy must therefore be settled one edge before a write strobe can be trusted.

Top module: `dp_busy_arbiter`

## Requirements
- R1: A collision is flagged only when both chip selects (active low) are asserted and both addresses are equal. Busy is raised only at the clock edge after a collision has been seen.
- R2: In deciding mode (`master_mode` = 1), during a collision exactly one port sees its busy output low and the other port's busy output stays high. Both busy outputs are never low together.
- R3: In deciding mode, a port whose busy output is low never gets its gated write enable asserted, even when it drives its write strobe.
- R4: Which port wins depends only on chip selects and addresses. Read or write strobe levels do not change the winner.
- R5: In follower mode (`master_mode` = 0), both busy outputs are held high. A low busy input blocks every write from its port, and a high one allows normal writes. In deciding mode the busy inputs have no effect.
- R6: The write gate uses the inhibit state captured at the last clock edge. A busy input that changes between edges does not affect the gated write enable until the next edge.
- R7: When both ports start a collision in the same cycle, the left port wins. When one port was already on that address in the previous cycle and the other was not, the port already there wins.
- R8: The winning port keeps ownership for as long as the collision persists. A change in the loser's read or write strobe does not change ownership.
- R9: Busy returns high at the first clock edge after the addresses differ or either chip select is released. An asserted reset clears all busy and inhibit state at once.
- R10: A gated write enable is high only when its port's chip select and write strobe are both low and the port is not inhibited. Reads never produce a write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = deciding unit, 0 = follower |
| l_ce_n | input | 1 | Left chip select, active low |
| l_addr | input | ADDR_W | Left address |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_in_n | input | 1 | Left write inhibit input in follower mode, active low |
| r_ce_n | input | 1 | Right chip select, active low |
| r_addr | input | ADDR_W | Right address |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_in_n | input | 1 | Right write inhibit input in follower mode, active low |
| l_busy_n | output | 1 | Busy flag to the left port, active low |
| r_busy_n | output | 1 | Busy flag to the right port, active low |
| l_wr_en | output | 1 | Gated write enable to the array, left port |
| r_wr_en | output | 1 | Gated write enable to the array, right port |

## Verification
The hardest case to reach is a collision where the right port wins. That only happens when the right port was already on the address one cycle before the left port arrived. The stimulus parks the right port on an address for one vector, then moves the left port onto it. It does this first with both ports reading, then with both writing, so the winner is shown to come from timing alone. The registered gate is checked by changing a busy input between edges and sampling before the next edge. Reset is asserted in the middle of a collision.

// File: rtl/dpba_pkg.sv
package dpba_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int PORTS = 2;
  localparam int P_L   = 0;
  localparam int P_R   = 1;

  // Winner of a freshly started collision: right only if it alone was there first.
  function automatic owner_e pick_winner(input logic l_was_there, input logic r_was_there);
    return (r_was_there && !l_was_there) ? OWN_RIGHT : OWN_LEFT;
  endfunction
endpackage

// File: rtl/dpba_collide.sv
module dpba_collide #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              collide,
  output logic              l_held,
  output logic              r_held
);
  logic              l_prev_v, r_prev_v;
  logic [ADDR_W-1:0] l_prev_a, r_prev_a;

  function automatic logic same_spot(input logic ce_a_n, input logic ce_b_n,
                                     input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return !ce_a_n && !ce_b_n && (a == b);
  endfunction

  assign collide = same_spot(l_ce_n, r_ce_n, l_addr, r_addr);
  // A port "holds" the address when it was selected on it during the previous cycle.
  assign l_held  = l_prev_v && !l_ce_n && (l_prev_a == l_addr);
  assign r_held  = r_prev_v && !r_ce_n && (r_prev_a == r_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_prev_v <= 1'b0;
      r_prev_v <= 1'b0;
      l_prev_a <= '0;
      r_prev_a <= '0;
    end else begin
      l_prev_v <= !l_ce_n;
      r_prev_v <= !r_ce_n;
      l_prev_a <= l_addr;
      r_prev_a <= r_addr;
    end
  end

  AST_COLLIDE_NEEDS_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> (!l_ce_n && !r_ce_n)); // R1
endmodule

// File: rtl/dpba_owner.sv
module dpba_owner
  import dpba_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   master_mode,
  input  logic   collide,
  input  logic   l_held,
  input  logic   r_held,
  output owner_e owner,
  output logic   lose_l,
  output logic   lose_r
);
  owner_e owner_d;

  always_comb begin
    owner_d = owner;
    if (!master_mode || !collide) owner_d = OWN_NONE;
    else if (owner == OWN_NONE)   owner_d = pick_winner(l_held, r_held);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else        owner <= owner_d;
  end

  assign lose_l = (owner == OWN_RIGHT);
  assign lose_r = (owner == OWN_LEFT);

  AST_KEEP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_LEFT && collide && master_mode) |=> (owner == OWN_LEFT)); // R8
  AST_KEEP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_RIGHT && collide && master_mode) |=> (owner == OWN_RIGHT)); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !collide |=> (owner == OWN_NONE)); // R9
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && collide && master_mode && !r_held) |=> (owner == OWN_LEFT)); // R7
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    !(lose_l && lose_r)); // R2
endmodule

// File: rtl/dpba_wgate.sv
module dpba_wgate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic ce_n,
  input  logic we_n,
  input  logic lose,
  input  logic busy_in_n,
  output logic inhibit,
  output logic wr_en
);
  logic ext_inh_q;

  // Follower inhibit is captured at the edge so the gate never sees a settling level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_inh_q <= 1'b0;
    else        ext_inh_q <= !busy_in_n;
  end

  assign inhibit = master_mode ? lose : ext_inh_q;
  assign wr_en   = !ce_n && !we_n && !inhibit;

  AST_FOLLOWER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !master_mode && $past(!busy_in_n)) |-> !wr_en); // R5
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we_n |-> !wr_en); // R10
endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we_n,
  input  logic              l_busy_in_n,
  input  logic              r_ce_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);
  logic   collide, l_held, r_held, lose_l, lose_r;
  owner_e owner;

  logic [PORTS-1:0] ce_v, we_v, lose_v, bin_v, inh_v, wr_v;

  dpba_collide #(.ADDR_W(ADDR_W)) u_collide (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_addr(l_addr),
    .r_ce_n(r_ce_n), .r_addr(r_addr),
    .collide(collide), .l_held(l_held), .r_held(r_held)
  );

  dpba_owner u_owner (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .collide(collide), .l_held(l_held), .r_held(r_held),
    .owner(owner), .lose_l(lose_l), .lose_r(lose_r)
  );

  assign ce_v   = {r_ce_n, l_ce_n};
  assign we_v   = {r_we_n, l_we_n};
  assign lose_v = {lose_r, lose_l};
  assign bin_v  = {r_busy_in_n, l_busy_in_n};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpba_wgate u_gate (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .ce_n(ce_v[p]), .we_n(we_v[p]), .lose(lose_v[p]),
      .busy_in_n(bin_v[p]), .inhibit(inh_v[p]), .wr_en(wr_v[p])
    );
  end

  assign l_busy_n = !(master_mode && lose_v[P_L]);
  assign r_busy_n = !(master_mode && lose_v[P_R]);
  assign l_wr_en  = wr_v[P_L];
  assign r_wr_en  = wr_v[P_R];

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_n || r_busy_n)); // R2
  AST_BUSY_BLOCKS_L: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n) |-> !l_wr_en); // R3
  AST_BUSY_BLOCKS_R: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !r_busy_n) |-> !r_wr_en); // R3
  AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n)); // R5
  AST_BUSY_AFTER_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> $past(collide)); // R1
endmodule

// File: tb/dp_busy_arbiter_bench.sv
`timescale 1ns/1ps
module dp_busy_arbiter_bench;
  localparam int AW = 14;

  typedef struct packed {
    logic       mode;
    logic       lce;
    logic [3:0] la;
    logic       lwe;
    logic       rce;
    logic [3:0] ra;
    logic       rwe;
    logic       lbin;
    logic       rbin;
    logic [3:0] exp;  // {l_busy_n, r_busy_n, l_wr_en, r_wr_en}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 4'h5, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 4'b1100, 4'd1},  // R1 lone read
    '{1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 4'h5, 1'b1, 1'b1, 1'b1, 4'b1010, 4'd7},  // R7 left there first
    '{1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 4'h5, 1'b0, 1'b1, 1'b1, 4'b1010, 4'd3},  // R3 R8 loser write blocked
    '{1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 4'h6, 1'b0, 1'b1, 1'b1, 4'b1111, 4'd9},  // R9 address differs
    '{1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 4'b1100, 4'd10}, // R10 idle
    '{1'b1, 1'b0, 4'h9, 1'b0, 1'b0, 4'h9, 1'b0, 1'b1, 1'b1, 4'b1010, 4'd7},  // R7 tie goes left
    '{1'b1, 1'b0, 4'h9, 1'b0, 1'b1, 4'h9, 1'b0, 1'b1, 1'b1, 4'b1110, 4'd9},  // R9 select released
    '{1'b1, 1'b1, 4'h3, 1'b1, 1'b0, 4'h3, 1'b1, 1'b1, 1'b1, 4'b1100, 4'd1},  // R1 right parks
    '{1'b1, 1'b0, 4'h3, 1'b1, 1'b0, 4'h3, 1'b1, 1'b1, 1'b1, 4'b0100, 4'd4},  // R4 R7 right wins on reads
    '{1'b1, 1'b0, 4'h3, 1'b0, 1'b0, 4'h3, 1'b0, 1'b1, 1'b1, 4'b0101, 4'd8},  // R8 right keeps on writes
    '{1'b1, 1'b0, 4'h3, 1'b0, 1'b1, 4'h3, 1'b0, 1'b1, 1'b1, 4'b1110, 4'd9},  // R9
    '{1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 4'h3, 1'b0, 1'b1, 1'b1, 4'b1111, 4'd5},  // R5 follower free
    '{1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 1'b1, 4'b1101, 4'd5},  // R5 left inhibited
    '{1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 4'h3, 1'b0, 1'b1, 1'b0, 4'b1110, 4'd5},  // R5 right inhibited
    '{1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 4'h3, 1'b0, 1'b0, 1'b0, 4'b1100, 4'd5},  // R5 both inhibited
    '{1'b1, 1'b0, 4'h7, 1'b0, 1'b0, 4'h7, 1'b0, 1'b0, 1'b0, 4'b1010, 4'd5}   // R5 inputs ignored when deciding
  };

  logic clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1;
  logic l_ce_n = 1'b1, l_we_n = 1'b1, l_busy_in_n = 1'b1;
  logic r_ce_n = 1'b1, r_we_n = 1'b1, r_busy_in_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_n, r_busy_n, l_wr_en, r_wr_en;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dp_busy_arbiter #(.ADDR_W(AW)) u_dp_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce_n(l_ce_n), .l_addr(l_addr), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
    .r_ce_n(r_ce_n), .r_addr(r_addr), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {l_busy_n, r_busy_n, l_wr_en, r_wr_en};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    master_mode = v.mode;
    l_ce_n = v.lce; l_addr = AW'(v.la); l_we_n = v.lwe; l_busy_in_n = v.lbin;
    r_ce_n = v.rce; r_addr = AW'(v.ra); r_we_n = v.rwe; r_busy_in_n = v.rbin;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state: no busy, both ports writing a shared address still pass
    master_mode = 1'b1;
    l_ce_n = 1'b0; r_ce_n = 1'b0; l_we_n = 1'b0; r_we_n = 1'b0;
    l_addr = AW'(2); r_addr = AW'(2);
    repeat (3) @(posedge clk);
    #1 check("R9 reset", 4'b1111);
    apply(VT[4]);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 after reset idle", 4'b1100);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i]);
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].exp);
    end

    // R6: follower inhibit changes between edges do not reach the gate
    apply('{1'b0, 1'b0, 4'h4, 1'b0, 1'b0, 4'h8, 1'b0, 1'b1, 1'b1, 4'b1111, 4'd6});
    @(posedge clk); #1;
    check("R6 follower open", 4'b1111);
    l_busy_in_n = 1'b0;
    #1 check("R6 mid-cycle inhibit not yet seen", 4'b1111);
    @(posedge clk); #1;
    check("R6 inhibit taken at edge", 4'b1101);

    // R9: asynchronous reset in the middle of a collision
    apply(VT[5]);
    @(posedge clk); #1;
    check("R2 collision before reset", 4'b1010);
    rst_n = 1'b0;
    #1 check("R9 reset clears busy", 4'b1111);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 new tie after reset goes left", 4'b1010);

    // R8: loser switching from write to read does not move ownership
    r_we_n = 1'b1;
    @(posedge clk); #1;
    check("R8 ownership kept", 4'b1010);
    finish_run();
  end
endmodule